// File: doc/BRIEF.md
# Misaligned Load Unit with Run-Time Byte Order

This block takes one load request at a time. A request is a byte address, an access size of one, two or four bytes, and a byte-order select. The block reads from a memory port that delivers one naturally aligned 32-bit word per read, with a fixed one-cycle latency and a valid strobe. When the requested bytes all lie inside one aligned word, the block makes one read. When they run past a 4-byte boundary, it makes two reads back to back and merges the bytes from both words.

The merged bytes are packed as either little-endian or big-endian, depending on the select captured with the request. The result is delivered right-justified and zero-extended, together with a one-cycle done pulse. Alongside the result, two flags report whether the address was a multiple of the access size.

The sequencer is a four-state machine: idle, first read, second read, finish. A busy output covers the time from acceptance until the result is delivered.

Top module: `mla_load_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, mem_rd_en, aligned and misaligned are low, and rd_data is zero.
- R2: A request (req_valid high) is taken only on a clock edge where busy is low. Busy and mem_rd_en are high in the cycle after that edge. While busy is high, req_valid and all request fields are ignored.
- R3: Each read pulses mem_rd_en for one cycle. The first read of a request uses the request address with its two low bits cleared. Byte lane i of mem_rd_data (bits 8i+7..8i) holds the byte at read address + i.
- R4: A request needs a second read when its address modulo 4, plus its size in bytes, exceeds 4. In that case the second read uses the first read address plus 4, wrapping within the address width, and is issued in the cycle after the first data is valid. Otherwise exactly one read is made.
- R5: With req_big_endian = 0, the byte at the lowest requested address goes to rd_data[7:0], and each higher address goes to the next more significant byte.
- R6: With req_big_endian = 1, the byte at the lowest requested address goes to the most significant byte of the result width, and each higher address goes to the next less significant byte.
- R7: req_size codes are 0 = byte, 1 = half-word, 2 = word, and 3 behaves as word. A result narrower than 32 bits is zero-extended.
- R8: When done is high, exactly one of aligned and misaligned is high. aligned is high when the address modulo the size in bytes is zero, even if two reads were needed for some other request. misaligned is high otherwise, even when only one read was made. Both flags, and rd_data, keep their values until the next done pulse.
- R9: done is high for exactly one cycle, and busy is low in that same cycle. With a one-cycle memory, done is high in the fourth cycle after the accepting edge for a one-read request and in the sixth for a two-read request. A request presented while done is high is accepted.
- R10: The byte order, size and address are sampled at acceptance. Changing them while busy does not alter the result or the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Size code: 0 byte, 1 half-word, 2 or 3 word |
| req_big_endian | input | 1 | 1 selects big-endian packing |
| busy | output | 1 | Request in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Word-aligned read address |
| mem_rd_valid | input | 1 | Read data valid, one cycle after mem_rd_en |
| mem_rd_data | input | DATA_W | Read data word |
| done | output | 1 | One-cycle result pulse |
| rd_data | output | DATA_W | Right-justified, zero-extended result |
| aligned | output | 1 | Address was a multiple of the size |
| misaligned | output | 1 | Address was not a multiple of the size |

## Verification
The delivery of one result and the acceptance of the next request can fall in the same cycle, because busy drops together with the done pulse. The bench provokes this by presenting the next request in the very cycle it observes done. It then checks both results, their read addresses and their latencies, the second one counted from its own acceptance. A second overlap is a new request, with a flipped byte order, held on the inputs while a boundary-crossing load is still reading. The held request must leave the first result and its two reads untouched.

// File: rtl/mla_pkg.sv
package mla_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ1 = 2'd1,
    ST_READ2 = 2'd2,
    ST_DONE  = 2'd3
  } mla_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Access width in bytes for a size code; code 3 is treated as a word.
  function automatic int unsigned size_to_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/mla_access_decode.sv
module mla_access_decode
  import mla_pkg::*;
#(
  parameter  int WB    = 4,
  localparam int OFF_W = $clog2(WB)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output logic [OFF_W:0]   nbytes,
  output logic             is_aligned,
  output logic             crosses
);

  logic [OFF_W-1:0] low_mask;
  logic [OFF_W:0]   span_end;

  always_comb begin
    nbytes   = (OFF_W+1)'(size_to_bytes(size));
    // For power-of-two sizes, address mod size is the low bits under size-1.
    low_mask = OFF_W'(nbytes - 1'b1);
    span_end = {1'b0, offset} + nbytes;
  end

  assign is_aligned = (offset & low_mask) == '0;
  assign crosses    = int'(span_end) > WB;

endmodule

// File: rtl/mla_byte_gather.sv
module mla_byte_gather #(
  parameter  int DATA_W = 32,
  localparam int WB     = DATA_W / 8,
  localparam int OFF_W  = $clog2(WB)
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W:0]    nbytes,
  input  logic              big_endian,
  output logic [DATA_W-1:0] result
);

  logic [2*DATA_W-1:0] pair;
  logic [WB-1:0][7:0]  pick;

  assign pair = {hi_word, lo_word};

  // pick[k] is the byte at request address + k, taken from the two-word window.
  for (genvar k = 0; k < WB; k++) begin : g_pick
    logic [OFF_W:0] idx;
    logic [7:0]     pk;
    assign idx = (OFF_W+1)'(offset) + (OFF_W+1)'(k);
    always_comb begin
      pk = 8'h00;
      for (int j = 0; j < 2*WB; j++) begin
        if (int'(idx) == j) pk = pair[8*j +: 8];
      end
    end
    assign pick[k] = pk;
  end

  // Output lane j: little-endian takes pick[j]; big-endian takes pick[n-1-j].
  for (genvar j = 0; j < WB; j++) begin : g_lane
    logic [7:0] ln;
    always_comb begin
      ln = 8'h00;
      if (int'(nbytes) > j) begin
        if (!big_endian) begin
          ln = pick[j];
        end else begin
          for (int m = 0; m < WB; m++) begin
            if (int'(nbytes) == m + j + 1) ln = pick[m];
          end
        end
      end
    end
    assign result[8*j +: 8] = ln;
  end

endmodule

// File: rtl/mla_load_unit.sv
module mla_load_unit
  import mla_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 32,
  localparam int WB     = DATA_W / 8,
  localparam int OFF_W  = $clog2(WB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_big_endian,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              aligned,
  output logic              misaligned
);

  mla_state_e        st;
  logic [OFF_W-1:0]  cap_off;
  logic [OFF_W:0]    cap_n;
  logic              cap_be;
  logic              cap_cross;
  logic              cap_aligned;
  logic [ADDR_W-1:0] base_addr;
  logic [DATA_W-1:0] word_lo;
  logic [DATA_W-1:0] word_hi;

  logic [OFF_W:0]    dec_n;
  logic              dec_aligned;
  logic              dec_cross;
  logic [ADDR_W-1:0] req_base;
  logic [DATA_W-1:0] merged;

  assign req_base = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  mla_access_decode #(.WB(WB)) u_decode (
    .offset     (req_addr[OFF_W-1:0]),
    .size       (req_size),
    .nbytes     (dec_n),
    .is_aligned (dec_aligned),
    .crosses    (dec_cross)
  );

  mla_byte_gather #(.DATA_W(DATA_W)) u_gather (
    .lo_word    (word_lo),
    .hi_word    (word_hi),
    .offset     (cap_off),
    .nbytes     (cap_n),
    .big_endian (cap_be),
    .result     (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      rd_data     <= '0;
      aligned     <= 1'b0;
      misaligned  <= 1'b0;
      cap_off     <= '0;
      cap_n       <= '0;
      cap_be      <= 1'b0;
      cap_cross   <= 1'b0;
      cap_aligned <= 1'b0;
      base_addr   <= '0;
      word_lo     <= '0;
      word_hi     <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cap_off     <= req_addr[OFF_W-1:0];
            cap_n       <= dec_n;
            cap_be      <= req_big_endian;
            cap_cross   <= dec_cross;
            cap_aligned <= dec_aligned;
            base_addr   <= req_base;
            word_hi     <= '0;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= req_base;
            busy        <= 1'b1;
            st          <= ST_READ1;
          end
        end
        ST_READ1: begin
          if (mem_rd_valid) begin
            word_lo <= mem_rd_data;
            if (cap_cross) begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= base_addr + ADDR_W'(WB);
              st          <= ST_READ2;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_READ2: begin
          if (mem_rd_valid) begin
            word_hi <= mem_rd_data;
            st      <= ST_DONE;
          end
        end
        ST_DONE: begin
          rd_data    <= merged;
          aligned    <= cap_aligned;
          misaligned <= !cap_aligned;
          done       <= 1'b1;
          busy       <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mla_load_unit_chk.sv
module mla_load_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              done,
  input logic              aligned,
  input logic              misaligned
);

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy && mem_rd_en));

  p_no_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en);

  p_read_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_read_addr_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));

  p_flags_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (aligned != misaligned));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(aligned) && $stable(misaligned)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind mla_load_unit mla_load_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .busy        (busy),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .done        (done),
  .aligned     (aligned),
  .misaligned  (misaligned)
);

// File: tb/mla_load_unit_tb_top.sv
module mla_load_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              req_big_endian = 1'b0;
  logic              busy, mem_rd_en, done, aligned, misaligned;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rd_valid;
  logic [DATA_W-1:0] mem_rd_data;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  logic [ADDR_W-1:0] rd_log [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  mla_load_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_big_endian(req_big_endian), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .done(done), .rd_data(rd_data),
    .aligned(aligned), .misaligned(misaligned)
  );

  function automatic logic [7:0] mbyte(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd37) + (a[15:8] * 8'd11) + 8'h5B;
  endfunction

  // Memory model: one-cycle latency, lane i holds byte at address + i.
  always @(posedge clk) begin
    if (rst) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
    end else begin
      mem_rd_valid <= mem_rd_en;
      for (int i = 0; i < 4; i++)
        mem_rd_data[8*i +: 8] <= mbyte(mem_rd_addr + ADDR_W'(i));
    end
  end

  always @(negedge clk) begin
    if (mem_rd_en) begin
      if (rd_cnt < 2) rd_log[rd_cnt] = mem_rd_addr;
      rd_cnt++;
    end
  end

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_data(input logic [ADDR_W-1:0] a,
                                           input logic [1:0] s, input logic be);
    logic [31:0] r;
    int n;
    r = '0;
    n = nb(s);
    for (int k = 0; k < n; k++) begin
      if (be) r[8*(n-1-k) +: 8] = mbyte(a + ADDR_W'(k));
      else    r[8*k +: 8]       = mbyte(a + ADDR_W'(k));
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input logic [1:0] s, input logic be);
    req_valid      = 1'b1;
    req_addr       = a;
    req_size       = s;
    req_big_endian = be;
    rd_cnt         = 0;
  endtask

  // Waits to the negedge where done is high; cyc counts negedges since issue.
  task automatic wait_done(output int cyc, input bit drop_now);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
        if (drop_now) req_valid = 1'b0;
      end
    end while (!done && cyc < 40);
  endtask

  task automatic judge(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                       input logic be, input int cyc);
    int n, nreads;
    logic [ADDR_W-1:0] base;
    bit al;
    n = nb(s);
    base = {a[ADDR_W-1:2], 2'b00};
    nreads = (int'(a[1:0]) + n > 4) ? 2 : 1;
    al = (int'(a[1:0]) % n) == 0;
    chk(rd_data === exp_data(a, s, be),
        be ? "R6 big-endian data" : "R5 little-endian data", rd_data, exp_data(a, s, be));
    if (n < 4)
      chk((rd_data >> (8*n)) == 0, "R7 zero extension", rd_data, exp_data(a, s, be));
    chk(aligned === al && misaligned === !al, "R8 alignment flags",
        {30'd0, aligned, misaligned}, {30'd0, al, !al});
    chk(rd_cnt == nreads, "R4 read count", 32'(rd_cnt), 32'(nreads));
    chk(rd_log[0] === base, "R3 first read address", 32'(rd_log[0]), 32'(base));
    if (nreads == 2)
      chk(rd_log[1] === base + 16'd4, "R4 second read address",
          32'(rd_log[1]), 32'(base + 16'd4));
    chk(cyc == (nreads == 2 ? 6 : 4), "R9 latency", 32'(cyc), nreads == 2 ? 32'd6 : 32'd4);
    chk(busy === 1'b0, "R9 busy low with done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    logic [ADDR_W-1:0] bases [3];
    logic [ADDR_W-1:0] a2;
    logic al0, mis0;
    logic [31:0] d0;
    bases[0] = 16'h0000; bases[1] = 16'h1230; bases[2] = 16'hFFF8;

    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && mem_rd_en === 0 && aligned === 0 &&
        misaligned === 0 && rd_data === 0, "R1 reset state", rd_data, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && mem_rd_en === 0 && rd_data === 0,
        "R1 after reset", {28'd0, busy, done, mem_rd_en, 1'b0}, 32'd0);

    // Sweep: every offset, size code and byte order at three bases (wrap included).
    for (int b = 0; b < 3; b++) begin
      for (int o = 0; o < 8; o++) begin
        for (int s = 0; s < 4; s++) begin
          for (int e = 0; e < 2; e++) begin
            a2 = bases[b] + ADDR_W'(o);
            issue(a2, 2'(s), e[0]);
            wait_done(cyc, 1'b1);
            judge(a2, 2'(s), e[0], cyc);
            al0 = aligned; mis0 = misaligned; d0 = rd_data;
            @(negedge clk);
            chk(done === 1'b0, "R9 done one cycle", 32'(done), 32'd0);
            chk(aligned === al0 && misaligned === mis0 && rd_data === d0,
                "R8 result held", rd_data, d0);
          end
        end
      end
    end

    // Back-to-back: next request presented in the done cycle.
    issue(16'h0403, 2'd2, 1'b1);
    wait_done(cyc, 1'b1);
    judge(16'h0403, 2'd2, 1'b1, cyc);
    issue(16'h0506, 2'd1, 1'b0);
    wait_done(cyc, 1'b1);
    judge(16'h0506, 2'd1, 1'b0, cyc);
    issue(16'h0607, 2'd1, 1'b1);
    wait_done(cyc, 1'b1);
    judge(16'h0607, 2'd1, 1'b1, cyc);
    @(negedge clk);

    // R10: request held while busy with different fields is ignored.
    issue(16'h2003, 2'd2, 1'b0);
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    req_addr = 16'h4000; req_size = 2'd0; req_big_endian = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 3;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    judge(16'h2003, 2'd2, 1'b0, cyc);
    chk(rd_data === exp_data(16'h2003, 2'd2, 1'b0), "R10 fields sampled at accept",
        rd_data, exp_data(16'h2003, 2'd2, 1'b0));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && rd_cnt == 2, "R2 held request not taken", 32'(rd_cnt), 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule